// File: doc/BRIEF.md
# Display Backlight PWM Generator

This block produces the dimming waveform for a display backlight. An 8-bit counter runs freely and wraps, so one output period always lasts 256 counter ticks. The output is found by comparing the counter with an 8-bit compare value. A polarity bit decides whether the part of the period below the compare value is driven high or low. The counter advances at a rate taken from one of two sources: a slow-clock strobe that arrives as a single-cycle enable in the system clock domain, or every system clock cycle. That rate is then divided by a power of two set by a 3-bit prescaler exponent.

Software writes one 16-bit configuration word that carries the compare value, the polarity and the prescaler exponent. The word is captured into a shadow copy. The working settings are loaded from the shadow copy only when the counter rolls over from 255 to 0, so a period already under way is never cut short. While the block is disabled, the counter and the prescaler are held at zero, the working settings follow the shadow copy, and the output is low. Enabling the block therefore starts a clean period with the newest settings.

Top module: `lpwm_top`

## Requirements
- R1: A synchronous active-low reset drives the output low and clears the counter, the prescaler, the shadow settings and the working settings. After reset, enabling the block with no configuration write gives a constant high output, because compare 0 with polarity 0 selects the inactive level high.
- R2: With polarity 1, the output is high while the counter is below the compare value and low otherwise.
- R3: With polarity 0, the output is the inverse of the polarity-1 waveform: low while the counter is below the compare value and high otherwise.
- R4: One period is exactly 256 counter ticks. With compare 255 and polarity 1, the output is high for 255 ticks and low for 1 tick, so full duty is never reached.
- R5: Compare value 0 gives a constant inactive level: always low with polarity 1 and always high with polarity 0.
- R6: The counter advances once every 2^P source pulses, where P is the 3-bit prescaler exponent (0 to 7, divide by 1 to 128).
- R7: When src_sel is 1, every system clock cycle is a source pulse and slow_stb is ignored. When src_sel is 0, only the cycles in which slow_stb is high are source pulses.
- R8: The configuration word is captured only in a cycle with cfg_we high. Its fields are: compare value in bits 15:8, polarity in bit 4, prescaler exponent in bits 2:0. Bits 7:5 and bit 3 are ignored.
- R9: A configuration written while the block is enabled takes effect only at the next counter rollover from 255 to 0. The period in progress finishes with the old compare value, polarity and prescaler exponent.
- R10: While en is low, the output is low, and the counter and the prescaler are held at zero. The shadow settings become the working settings one cycle after they are written. Counting restarts from zero when en goes high.
- R11: The output is registered. The level seen after clock edge n reflects the counter value and working settings that were present before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; low holds the counter and drives the output low |
| src_sel | input | 1 | Counter source: 0 selects the slow strobe, 1 selects the system clock |
| slow_stb | input | 1 | Single-cycle strobe standing in for the slow clock |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_word | input | 16 | Configuration word: compare value, polarity and prescaler exponent |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
A wrong counter or prescaler state changes the position of the edges of pwm_out. Because the bench predicts every output cycle from the number of source pulses, the first misplaced edge is caught within one tick of the fault. A reload applied at the wrong moment shows up as a period whose pulse width matches neither the old nor the new compare value, within one period of the write. A working setting that fails to follow the shadow copy while disabled shows up in the very first cycle after enabling, as the wrong output level.

// File: rtl/lpwm_pkg.sv
`timescale 1ns/1ps
package lpwm_pkg;

  localparam int CNT_W   = 8;
  localparam int PS_W    = 3;
  localparam int CFG_W   = 16;
  localparam int CMP_LSB = 8;
  localparam int POL_POS = 4;
  localparam int PS_LSB  = 0;
  localparam int PRE_W   = (1 << PS_W) - 1;

  typedef struct packed {
    logic [CNT_W-1:0] cmp;
    logic             pol;
    logic [PS_W-1:0]  ps;
  } lpwm_cfg_t;

  // Split a configuration word into its fields; unused bits drop out here.
  function automatic lpwm_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    lpwm_cfg_t c;
    c.cmp = w[CMP_LSB +: CNT_W];
    c.pol = w[POL_POS];
    c.ps  = w[PS_LSB +: PS_W];
    return c;
  endfunction

  // Low-order ones mask: 2^ps - 1, the terminal count of the prescaler.
  function automatic logic [PRE_W-1:0] pre_mask(input logic [PS_W-1:0] ps);
    logic [PRE_W:0] pow;
    pow = '0;
    pow[ps] = 1'b1;
    pow = pow - (PRE_W+1)'(1);
    return pow[PRE_W-1:0];
  endfunction

  // Output level for a counter value under a compare value and polarity.
  function automatic logic drive_level(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] cmp,
                                       input logic             pol);
    logic below;
    below = (cnt < cmp);
    return (below == pol);
  endfunction

endpackage

// File: rtl/lpwm_tick_gen.sv
`timescale 1ns/1ps
module lpwm_tick_gen
  import lpwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            src_sel,
  input  logic            slow_stb,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             src_pulse;

  always_comb begin
    src_pulse = src_sel | slow_stb;
    mask      = pre_mask(ps);
    tick      = run && src_pulse && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
    end else if (src_pulse) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/lpwm_counter.sv
`timescale 1ns/1ps
module lpwm_counter
  import lpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt  = cnt_q;
    wrap = tick && (cnt_q == '1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/lpwm_cfg_shadow.sv
`timescale 1ns/1ps
module lpwm_cfg_shadow
  import lpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_word,
  input  logic             reload,
  output lpwm_cfg_t        act_cfg
);

  lpwm_cfg_t shadow_q;
  lpwm_cfg_t act_q;

  assign act_cfg = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (wr_en) begin
        shadow_q <= cfg_unpack(wr_word);
      end
      if (!run || reload) begin
        act_q <= shadow_q;
      end
    end
  end

endmodule

// File: rtl/lpwm_top.sv
`timescale 1ns/1ps
module lpwm_top
  import lpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             src_sel,
  input  logic             slow_stb,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             pwm_out
);

  logic             tick_w;
  logic             wrap_w;
  logic [CNT_W-1:0] cnt_w;
  lpwm_cfg_t        act_cfg_w;
  logic             level_w;
  logic             out_q;

  lpwm_cfg_shadow u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .wr_en   (cfg_we),
    .wr_word (cfg_word),
    .reload  (wrap_w),
    .act_cfg (act_cfg_w)
  );

  lpwm_tick_gen u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en),
    .src_sel  (src_sel),
    .slow_stb (slow_stb),
    .ps       (act_cfg_w.ps),
    .tick     (tick_w)
  );

  lpwm_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en),
    .tick  (tick_w),
    .cnt   (cnt_w),
    .wrap  (wrap_w)
  );

  always_comb level_w = drive_level(cnt_w, act_cfg_w.cmp, act_cfg_w.pol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= en && level_w;
    end
  end

  assign pwm_out = out_q;

endmodule

// File: rtl/lpwm_chk.sv
`timescale 1ns/1ps
module lpwm_chk
  import lpwm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             src_sel,
  input logic             slow_stb,
  input logic             tick,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input lpwm_cfg_t        act_cfg,
  input logic             pwm_out
);

  // R1
  a_r1_reset_out_low: assert property (@(posedge clk)
    !rst_n |=> !pwm_out);

  // R10
  a_r10_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out);

  // R9
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    en && !wrap |=> $stable(act_cfg));

  // R4
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  // R6
  a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    en && tick |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R6
  a_r6_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    en && !tick |=> $stable(cnt));

  // R7
  a_r7_slow_gate: assert property (@(posedge clk) disable iff (!rst_n)
    en && !src_sel && !slow_stb |-> !tick);

  // R5
  a_r5_zero_cmp_low: assert property (@(posedge clk) disable iff (!rst_n)
    en && (act_cfg.cmp == '0) && act_cfg.pol |=> !pwm_out);

endmodule

bind lpwm_top lpwm_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .src_sel  (src_sel),
  .slow_stb (slow_stb),
  .tick     (tick_w),
  .wrap     (wrap_w),
  .cnt      (cnt_w),
  .act_cfg  (act_cfg_w),
  .pwm_out  (pwm_out)
);

// File: tb/lpwm_top_tb_top.sv
`timescale 1ns/1ps
module lpwm_top_tb_top;

  localparam real HALF = 2.0;
  localparam int  WD_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        src_sel = 1'b0;
  logic        slow_stb = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_word = 16'h0000;
  logic        pwm_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // bench model of shadow and working settings
  int a_cmp = 0, a_pol = 0, a_ps = 0;
  int s_cmp = 0, s_pol = 0, s_ps = 0;

  always #(HALF) clk = ~clk;

  lpwm_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .src_sel  (src_sel),
    .slow_stb (slow_stb),
    .cfg_we   (cfg_we),
    .cfg_word (cfg_word),
    .pwm_out  (pwm_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare in 15:8, polarity in 4, exponent in 2:0; junk fills 7:5 and 3
  function automatic logic [15:0] mk_word(input int cmp, input int pol,
                                          input int ps, input bit junk);
    logic [15:0] w;
    w = {cmp[7:0], 3'b000, pol[0], 1'b0, ps[2:0]};
    if (junk) w = w | 16'h00E8;
    return w;
  endfunction

  task automatic load_idle(input int cmp, input int pol, input int ps, input bit junk);
    en = 1'b0;
    cfg_we = 1'b1;
    cfg_word = mk_word(cmp, pol, ps, junk);
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_word = 16'h5AA5;
    @(negedge clk);
    @(negedge clk);
    s_cmp = cmp; s_pol = pol; s_ps = ps;
    a_cmp = cmp; a_pol = pol; a_ps = ps;
  endtask

  // Runs ncyc enabled cycles and predicts each output from the pulse count.
  task automatic run_loop(input int ncyc, input bit src, input int sdiv,
                          input int wr_at, input logic [15:0] wr_w,
                          input string req, input string what);
    int  m_rel = 0;
    bit  bad = 1'b0;
    int  bad_n = 0, bad_act = 0, bad_exp = 0;
    en = 1'b1;
    src_sel = src;
    for (int n = 1; n <= ncyc; n++) begin
      bit   stb;
      bit   pulse;
      int   cnt_e;
      logic exp;
      stb   = ((n % sdiv) == 0);
      pulse = src ? 1'b1 : stb;
      slow_stb = stb;
      cfg_we   = (n == wr_at);
      cfg_word = (n == wr_at) ? wr_w : (16'hC33C ^ 16'(n));
      cnt_e = (m_rel >> a_ps) & 255;
      exp   = (cnt_e < a_cmp) ? a_pol[0] : !a_pol[0];
      @(negedge clk);
      if (pwm_out !== exp && !bad) begin
        bad = 1'b1; bad_n = n; bad_act = int'(pwm_out); bad_exp = int'(exp);
      end
      if (pulse) begin
        m_rel++;
        if (m_rel == (256 << a_ps)) begin
          a_cmp = s_cmp; a_pol = s_pol; a_ps = s_ps;
          m_rel = 0;
        end
      end
      if (n == wr_at) begin
        s_cmp = int'(wr_w[15:8]); s_pol = int'(wr_w[4]); s_ps = int'(wr_w[2:0]);
      end
    end
    cfg_we = 1'b0;
    slow_stb = 1'b0;
    if (bad) $display("  first mismatch at enabled cycle %0d", bad_n);
    check(!bad, req, what, bad_act, bad_exp);
  endtask

  initial begin
    #(HALF * 2.0 * WD_CYCLES);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d (cycles to finish)", WD_CYCLES, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pwm_out === 1'b0, "R1", "output during reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out === 1'b0, "R1", "output after reset, disabled", int'(pwm_out), 0);

    // R1: cleared settings give compare 0, polarity 0 -> constant high
    run_loop(300, 1'b1, 7, 0, 16'h0, "R1", "reset defaults waveform");

    // R2 / R3: mid-scale compare with both polarities; R8 junk bits set
    load_idle(128, 1, 0, 1'b0);
    run_loop(600, 1'b1, 5, 0, 16'h0, "R2", "cmp 128 pol 1");
    load_idle(128, 0, 0, 1'b1);
    run_loop(600, 1'b1, 5, 0, 16'h0, "R3", "cmp 128 pol 0 (R8 junk bits)");
    load_idle(1, 1, 0, 1'b0);
    run_loop(600, 1'b1, 3, 0, 16'h0, "R2", "cmp 1 pol 1");
    load_idle(200, 0, 0, 1'b0);
    run_loop(600, 1'b1, 3, 0, 16'h0, "R3", "cmp 200 pol 0");

    // R4: maximum compare leaves one low tick per period
    load_idle(255, 1, 0, 1'b0);
    begin
      int lows = 0;
      en = 1'b1;
      src_sel = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        if (pwm_out === 1'b0) lows++;
      end
      check(lows == 1, "R4", "low ticks per period at cmp 255", lows, 1);
    end
    load_idle(255, 1, 0, 1'b0);
    run_loop(700, 1'b1, 4, 0, 16'h0, "R4", "cmp 255 waveform over wraps");

    // R5: zero compare, both polarities
    load_idle(0, 1, 0, 1'b0);
    run_loop(400, 1'b1, 4, 0, 16'h0, "R5", "cmp 0 pol 1 constant low");
    load_idle(0, 0, 0, 1'b0);
    run_loop(400, 1'b1, 4, 0, 16'h0, "R5", "cmp 0 pol 0 constant high");

    // R10: disabling forces low even with a high inactive level
    en = 1'b0;
    begin
      int highs = 0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (pwm_out !== 1'b0) highs++;
      end
      check(highs == 0, "R10", "high cycles while disabled", highs, 0);
    end

    // R6: prescaler exponent sweep 1..7
    for (int p = 1; p <= 7; p++) begin
      load_idle((37 * p) & 255, p & 1, p, p[1]);
      run_loop((256 << p) + 300, 1'b1, 6, 0, 16'h0, "R6", $sformatf("prescaler exponent %0d", p));
    end

    // R7: slow strobe source, every third cycle, exponent 1
    load_idle(100, 1, 1, 1'b0);
    run_loop(2000, 1'b0, 3, 0, 16'h0, "R7", "slow strobe source");
    load_idle(60, 0, 0, 1'b0);
    run_loop(1400, 1'b0, 2, 0, 16'h0, "R7", "slow strobe every other cycle");

    // R9: write while running takes effect at the rollover only
    load_idle(50, 1, 0, 1'b0);
    run_loop(1200, 1'b1, 9, 100, mk_word(200, 0, 1, 1'b1), "R9", "reload at rollover");
    load_idle(30, 0, 1, 1'b0);
    run_loop(1400, 1'b1, 9, 500, mk_word(90, 1, 0, 1'b0), "R9", "reload with smaller exponent");

    // R10 / R11: restart from zero after disable mid-period; new settings immediate
    load_idle(10, 1, 0, 1'b0);
    run_loop(40, 1'b1, 5, 0, 16'h0, "R11", "registered output start");
    load_idle(10, 1, 0, 1'b0);
    run_loop(300, 1'b1, 5, 0, 16'h0, "R10", "counter restart after disable");

    en = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule